// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a set of clean, already-digitized supervisory flags into a processor reset. It watches a flag that is true while the main supply is above its reset threshold, a raw active-low manual reset request, and a low-line flag. It drives a complementary pair of reset outputs, one active low and one active high. Reset is held whenever the supply is bad or a qualified manual request is active. It is released only after a selectable timeout has run without a break once every fault has cleared.

The manual request must stay low for a minimum width before it is accepted, so contact bounce and short glitches are rejected. An accepted request asserts reset after a further fixed delay. Supply faults and manual faults feed one shared timeout counter, and any new fault restarts it from zero. The low-line flag is synchronized and brought out as an independent active-low early-warning output. It can serve as a non-maskable interrupt source ahead of the reset.

All intervals are cycle counts derived from two parameters: clock cycles per microsecond (`CYC_PER_US`) and clock cycles per millisecond (`CYC_PER_MS`). Let MIN = 25·`CYC_PER_US`, DLY = 12·`CYC_PER_US`, and let P be the timeout in cycles picked by the select input.

Top module: `sup_reset_seq`

## Requirements
- R1: When `pgood_i` goes low, `sys_rst_n_o` is low by the third rising clock edge, and it stays low for as long as `pgood_i` stays low.
- R2: After `pgood_i` rises with no other fault present, `sys_rst_n_o` is still low after P+1 rising edges and is high after P+2 rising edges.
- R3: If `pgood_i` falls again before the timeout completes, reset stays asserted, and the full timeout is counted again from the next rise of `pgood_i`.
- R4: A low pulse on `mr_req_n_i` that is sampled on fewer than MIN consecutive rising edges is ignored and leaves reset released. A pulse sampled on exactly MIN edges is accepted.
- R5: After an accepted manual request, reset asserts on rising edge MIN+DLY+3, counted from the first edge that samples `mr_req_n_i` low, and not on the edge before.
- R6: Reset stays asserted while an accepted manual request is held low. After `mr_req_n_i` returns high, reset is still low after P+2 rising edges and is high after P+3.
- R7: The timeout select `tsel_i` gives P = 1.4·`CYC_PER_MS` for code 00, 28·`CYC_PER_MS` for 01, 200·`CYC_PER_MS` for 10, and 1600·`CYC_PER_MS` for 11.
- R8: `sys_rst_o` is always the inverse of `sys_rst_n_o`.
- R9: While `rst` is high, reset is asserted and the timeout is cleared, so the first release after block reset needs a full timeout.
- R10: `early_warn_n_o` equals the inverse of `vcc_low_i` delayed by two rising edges. It has no effect on the reset outputs.
- R11: A change of `tsel_i` while a timeout is counting does not alter that timeout. The new code is used from the next restart.
- R12: Supply and manual faults share one timeout. Reset releases only after both have cleared, and the timeout runs from the later of the two clearing points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| pgood_i | input | 1 | Supply above reset threshold (asynchronous) |
| mr_req_n_i | input | 1 | Raw manual reset request, active low (asynchronous) |
| vcc_low_i | input | 1 | Low-line flag, high when supply nears threshold (asynchronous) |
| tsel_i | input | 2 | Timeout period select code |
| sys_rst_n_o | output | 1 | Processor reset, active low |
| sys_rst_o | output | 1 | Processor reset, active high |
| early_warn_n_o | output | 1 | Synchronized early power-fail warning, active low |

## Verification
Supply faults and manual faults can overlap. A manual request can still be in its hold state when the supply flag drops or rises, and the timeout must then start from whichever source clears last. The bench provokes this in both orders. In one order the manual request is held through a supply drop and released while the supply is still bad. In the other the supply recovers while the button is still held. In each case it checks that reset stays asserted until exactly the timeout after the last clearing edge. It also changes the timeout select in the middle of a running count and checks that the count already in progress keeps its original period.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        TO_SHORT = 2'b00,
        TO_MID   = 2'b01,
        TO_LONG  = 2'b10,
        TO_MAX   = 2'b11
    } tsel_e;

    typedef enum logic [1:0] {
        MR_IDLE  = 2'b00,
        MR_DELAY = 2'b01,
        MR_HOLD  = 2'b10
    } mr_state_e;

    typedef struct packed {
        logic pgood;
        logic mr_n;
        logic vlow;
    } sup_in_t;

    localparam sup_in_t SUP_IN_RST = '{pgood: 1'b0, mr_n: 1'b1, vlow: 1'b0};

    function automatic int unsigned timeout_cycles(tsel_e sel, int unsigned cyc_ms);
        case (sel)
            TO_SHORT: return (14 * cyc_ms) / 10;
            TO_MID:   return 28 * cyc_ms;
            TO_LONG:  return 200 * cyc_ms;
            default:  return 1600 * cyc_ms;
        endcase
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned    W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[b];
                s2 <= RST_VAL[b];
            end else begin
                s1 <= d_i[b];
                s2 <= s1;
            end
        end
        assign q_o[b] = s2;
    end
endmodule

// File: rtl/sup_mr_qual.sv
module sup_mr_qual
    import sup_pkg::*;
#(
    parameter int unsigned MIN_LOW = 50,
    parameter int unsigned DLY     = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n_s,
    output logic mr_fault
);
    localparam int unsigned LOW_W = $clog2(MIN_LOW + 1);
    localparam int unsigned DLY_W = $clog2(DLY + 1);

    mr_state_e          st_q;
    logic [LOW_W-1:0]   low_cnt_q;
    logic [DLY_W-1:0]   dly_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= MR_IDLE;
            low_cnt_q <= '0;
            dly_cnt_q <= '0;
        end else begin
            case (st_q)
                MR_IDLE: begin
                    dly_cnt_q <= '0;
                    if (mr_n_s) begin
                        low_cnt_q <= '0;
                    end else if (low_cnt_q == LOW_W'(MIN_LOW - 1)) begin
                        low_cnt_q <= '0;
                        st_q      <= MR_DELAY;
                    end else begin
                        low_cnt_q <= low_cnt_q + 1'b1;
                    end
                end
                MR_DELAY: begin
                    if (dly_cnt_q == DLY_W'(DLY - 1)) begin
                        dly_cnt_q <= '0;
                        st_q      <= MR_HOLD;
                    end else begin
                        dly_cnt_q <= dly_cnt_q + 1'b1;
                    end
                end
                MR_HOLD: begin
                    if (mr_n_s) st_q <= MR_IDLE;
                end
                default: st_q <= MR_IDLE;
            endcase
        end
    end

    assign mr_fault = (st_q == MR_HOLD);
endmodule

// File: rtl/sup_timer.sv
module sup_timer
    import sup_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 200000,
    parameter int unsigned CNT_W      = 29
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fault,
    input  logic [1:0] tsel,
    output logic       rst_act
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic             act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            per_q <= CNT_W'(timeout_cycles(TO_SHORT, CYC_PER_MS));
            act_q <= 1'b1;
        end else if (fault) begin
            cnt_q <= '0;
            per_q <= CNT_W'(timeout_cycles(tsel_e'(tsel), CYC_PER_MS));
            act_q <= 1'b1;
        end else if (act_q) begin
            if (cnt_q == per_q - 1'b1) begin
                act_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_act = act_q;
endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
    import sup_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 200,
    parameter int unsigned CYC_PER_MS = 200000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pgood_i,
    input  logic       mr_req_n_i,
    input  logic       vcc_low_i,
    input  logic [1:0] tsel_i,
    output logic       sys_rst_n_o,
    output logic       sys_rst_o,
    output logic       early_warn_n_o
);
    localparam int unsigned MR_MIN = 25 * CYC_PER_US;
    localparam int unsigned MR_DLY = 12 * CYC_PER_US;
    localparam int unsigned T_MAX  = timeout_cycles(TO_MAX, CYC_PER_MS);
    localparam int unsigned CNT_W  = $clog2(T_MAX + 1);

    sup_in_t raw_in;
    sup_in_t syn_in;
    logic    pgood_s;
    logic    mr_fault;
    logic    fault;
    logic    rst_act;

    assign raw_in = '{pgood: pgood_i, mr_n: mr_req_n_i, vlow: vcc_low_i};

    sup_sync #(.W($bits(sup_in_t)), .RST_VAL(SUP_IN_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (syn_in)
    );

    assign pgood_s = syn_in.pgood;

    sup_mr_qual #(.MIN_LOW(MR_MIN), .DLY(MR_DLY)) u_mr (
        .clk      (clk),
        .rst      (rst),
        .mr_n_s   (syn_in.mr_n),
        .mr_fault (mr_fault)
    );

    assign fault = !pgood_s || mr_fault;

    sup_timer #(.CYC_PER_MS(CYC_PER_MS), .CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .fault   (fault),
        .tsel    (tsel_i),
        .rst_act (rst_act)
    );

    assign sys_rst_n_o    = !rst_act;
    assign sys_rst_o      = rst_act;
    assign early_warn_n_o = !syn_in.vlow;
endmodule

// File: rtl/sup_reset_seq_chk.sv
module sup_reset_seq_chk (
    input logic clk,
    input logic rst,
    input logic pgood_s,
    input logic mr_fault,
    input logic sys_rst_n_o,
    input logic sys_rst_o
);
    // R1
    pgood_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pgood_s |=> !sys_rst_n_o);

    // R2
    release_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n_o) |-> ($past(pgood_s) && !$past(mr_fault)));

    // R6
    mr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mr_fault |=> !sys_rst_n_o);

    // R8
    polarity_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o != sys_rst_n_o);

    // R9
    blk_reset_chk: assert property (@(posedge clk)
        rst |=> !sys_rst_n_o);
endmodule

bind sup_reset_seq sup_reset_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pgood_s     (pgood_s),
    .mr_fault    (mr_fault),
    .sys_rst_n_o (sys_rst_n_o),
    .sys_rst_o   (sys_rst_o)
);

// File: tb/sup_reset_seq_tb.sv
`timescale 1ns/1ps
module sup_reset_seq_tb;
    localparam int US  = 2;
    localparam int MS  = 20;
    localparam int MIN = 25 * US;
    localparam int DLY = 12 * US;

    logic       clk = 1'b0;
    logic       rst;
    logic       pgood, mr_n, vlow;
    logic [1:0] tsel;
    logic       rst_n_o, rst_o, warn_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sup_reset_seq #(.CYC_PER_US(US), .CYC_PER_MS(MS)) u_dut (
        .clk            (clk),
        .rst            (rst),
        .pgood_i        (pgood),
        .mr_req_n_i     (mr_n),
        .vcc_low_i      (vlow),
        .tsel_i         (tsel),
        .sys_rst_n_o    (rst_n_o),
        .sys_rst_o      (rst_o),
        .early_warn_n_o (warn_n)
    );

    function automatic int period(input logic [1:0] s);
        case (s)
            2'b00:   return (14 * MS) / 10;
            2'b01:   return 28 * MS;
            2'b10:   return 200 * MS;
            default: return 1600 * MS;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected: 1 = reset asserted
    task automatic chk_rst(input bit exp_on, input string req);
        chk(rst_n_o == !exp_on, req, rst_n_o, !exp_on);
        chk(rst_o == !rst_n_o, "R8", rst_o, !rst_n_o);
    endtask

    // call right after a negedge that changed the releasing input
    task automatic expect_release(input int n, input string req);
        repeat (n) @(posedge clk);
        #1 chk_rst(1'b1, req);
        @(posedge clk);
        #1 chk_rst(1'b0, req);
    endtask

    task automatic t_reset();
        rst = 1'b1; pgood = 1'b1; mr_n = 1'b1; vlow = 1'b0; tsel = 2'b00;
        repeat (3) @(posedge clk);
        #1 chk_rst(1'b1, "R9");
        chk(warn_n == 1'b1, "R9", warn_n, 1);
        @(negedge clk) rst = 1'b0;
        expect_release(period(2'b00) + 1, "R9");
    endtask

    task automatic t_codes();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk) begin pgood = 1'b0; tsel = 2'(s); end
            repeat (2) @(posedge clk);
            #1 chk_rst(1'b0, "R1");
            @(posedge clk);
            #1 chk_rst(1'b1, "R1");
            repeat (20) @(posedge clk);
            #1 chk_rst(1'b1, "R1");
            @(negedge clk) pgood = 1'b1;
            expect_release(period(2'(s)) + 1, "R7");
        end
        tsel = 2'b00;
    endtask

    task automatic t_retrigger();
        @(negedge clk) pgood = 1'b0;
        repeat (5) @(negedge clk);
        pgood = 1'b1;
        repeat (15) @(posedge clk);
        #1 chk_rst(1'b1, "R3");
        @(negedge clk) pgood = 1'b0;
        repeat (3) @(negedge clk);
        pgood = 1'b1;
        expect_release(period(2'b00) + 1, "R3");
    endtask

    task automatic t_mr_short();
        bit seen = 1'b0;
        @(negedge clk) mr_n = 1'b0;
        repeat (MIN - 1) @(negedge clk);
        mr_n = 1'b1;
        for (int i = 0; i < MIN + DLY + 10; i++) begin
            @(posedge clk);
            #1 if (!rst_n_o) seen = 1'b1;
        end
        chk(seen == 1'b0, "R4", seen, 0);
    endtask

    task automatic t_mr_accept();
        @(negedge clk) mr_n = 1'b0;
        repeat (MIN) @(negedge clk);
        mr_n = 1'b1;
        repeat (DLY + 2) @(posedge clk);
        #1 chk_rst(1'b0, "R5");
        @(posedge clk);
        #1 chk_rst(1'b1, "R4");
        repeat (period(2'b00) + 4) @(posedge clk);
        #1 chk_rst(1'b0, "R5");
    endtask

    task automatic t_mr_hold();
        @(negedge clk) mr_n = 1'b0;
        repeat (300) @(negedge clk);
        #0 chk_rst(1'b1, "R6");
        mr_n = 1'b1;
        expect_release(period(2'b00) + 2, "R6");
    endtask

    task automatic t_sel_change();
        @(negedge clk) pgood = 1'b0;
        repeat (4) @(negedge clk);
        pgood = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk) tsel = 2'b11;
        repeat (period(2'b00) + 1 - 6) @(posedge clk);
        #1 chk_rst(1'b1, "R11");
        @(posedge clk);
        #1 chk_rst(1'b0, "R11");
        @(negedge clk) tsel = 2'b00;
    endtask

    task automatic t_overlap();
        // manual held, supply drops, manual released while supply still bad
        @(negedge clk) mr_n = 1'b0;
        repeat (MIN + DLY + 10) @(negedge clk);
        pgood = 1'b0;
        repeat (10) @(negedge clk);
        mr_n = 1'b1;
        repeat (period(2'b00) + 20) @(negedge clk);
        #0 chk_rst(1'b1, "R12");
        pgood = 1'b1;
        expect_release(period(2'b00) + 1, "R12");
        // supply recovers while manual still held
        @(negedge clk) mr_n = 1'b0;
        repeat (MIN + DLY + 10) @(negedge clk);
        pgood = 1'b0;
        repeat (10) @(negedge clk);
        pgood = 1'b1;
        repeat (period(2'b00) + 20) @(negedge clk);
        #0 chk_rst(1'b1, "R12");
        mr_n = 1'b1;
        expect_release(period(2'b00) + 2, "R12");
    endtask

    task automatic t_early();
        @(negedge clk) vlow = 1'b1;
        @(posedge clk);
        #1 chk(warn_n == 1'b1, "R10", warn_n, 1);
        @(posedge clk);
        #1 chk(warn_n == 1'b0, "R10", warn_n, 0);
        repeat (10) @(posedge clk);
        #1 chk_rst(1'b0, "R10");
        @(negedge clk) vlow = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk(warn_n == 1'b1, "R10", warn_n, 1);
        chk_rst(1'b0, "R10");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_codes();
        t_retrigger();
        t_mr_short();
        t_mr_accept();
        t_mr_hold();
        t_sel_change();
        t_overlap();
        t_early();
        summary();
        $finish;
    end
endmodule